// File: doc/BRIEF.md
# Boundary-Scanned Dual-Bank Transparent Latch

The block holds two independent banks of nine transparent D latches, called bank A and bank B. Each bank has its own latch-enable input and its own active-low output-enable pin. Tri-state pins are modelled as a data bus plus one drive-enable signal per bank. When the drive enable is 0 the pins are to be treated as high impedance.

Around the core sits a 42-cell boundary-scan register. An external test-access-port controller drives it through capture, shift and update strobes plus a two-bit mode code. Cells on input pins can only observe. Cells on output pins, and cells on the two internal active-high bank enables, can also take over their net.

Capture and shift act on the rising TCK edge. The update registers load on the falling TCK edge. In test modes the pins and enables come from the update registers. Otherwise system data passes straight through.

Top module: `dbl_scan_latch`

## Requirements
- R1: With `scan_mode` = 0 (system) and a bank's latch enable at 1, that bank's `*_out` equals its `*_in` and follows every change of it.
- R2: After a bank's latch enable goes from 1 to 0, `*_out` keeps the value the input had just before the fall, whatever the input does afterwards.
- R3: In system mode, `*_drv` is the inverse of the bank's `*_oe_n` pin. Latches still load while `*_oe_n` is 1, so re-enabling shows the newly latched data.
- R4: The chain is 42 cells long. `tdi` enters cell 41 and `tdo` shows cell 0. A pattern shifted in reappears on `tdo` exactly 42 shifts later, lowest index first.
- R5: A capture strobe loads every cell from its net, with fixed indices. Cell 41 is the A output-enable pin and cell 40 the A latch enable. Cell 39 is the internal A enable (the inverted pin). Cells 38, 37 and 36 are the same three nets for bank B. Cells 35-k hold A input bit k and cells 26-k hold B input bit k. Cells 17-k hold A latch output bit k and cells 8-k hold B latch output bit k, for k = 0..8.
- R6: Update registers load on the falling TCK edge that follows an update strobe and not before. In `scan_mode` = 1 (external test), `a_out` bit k = update cell 17-k, `b_out` bit k = cell 8-k, `a_drv` = cell 39 and `b_drv` = cell 36, with 1 meaning enabled.
- R7: `scan_mode` = 2 (clamp) drives the pins and enables from the update registers exactly as in external test.
- R8: `scan_mode` = 3 (high-Z) forces `a_drv` and `b_drv` to 0.
- R9: Reset, and a `tap_reset` strobe seen on a falling TCK edge, clear every update register. External test then shows both banks disabled with all-zero data.
- R10: In system mode, capture, shift and update activity leaves `a_out`, `b_out`, `a_drv` and `b_drv` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset of the scan logic |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output (cell 0) |
| dr_capture | input | 1 | Capture strobe from the TAP controller |
| dr_shift | input | 1 | Shift strobe from the TAP controller |
| dr_update | input | 1 | Update strobe from the TAP controller |
| tap_reset | input | 1 | Test-logic-reset state indication |
| scan_mode | input | 2 | 0 system, 1 external test, 2 clamp, 3 high-Z |
| a_in | input | 9 | Bank A data inputs |
| a_le | input | 1 | Bank A latch enable, active high |
| a_oe_n | input | 1 | Bank A output-enable pin, active low |
| b_in | input | 9 | Bank B data inputs |
| b_le | input | 1 | Bank B latch enable, active high |
| b_oe_n | input | 1 | Bank B output-enable pin, active low |
| a_out | output | 9 | Bank A pin data |
| a_drv | output | 1 | Bank A pins driven when 1 |
| b_out | output | 9 | Bank B pin data |
| b_drv | output | 1 | Bank B pins driven when 1 |

## Verification
Directed sequences cover the latch behaviour. One opens a latch and changes its data. One closes the latch and then changes its data. One disables the outputs while loading new data. Together they separate a transparent latch from an edge-triggered register or a gated path.

Random streams of data, latch enable and output enable are then compared against a bench latch model. Random scan images are captured and shifted out, which pins each net to its cell index. The same images are updated and viewed in each of the four modes, which shows whether the mux draws from the update registers, from the system path or from neither.

A pure shift-through and a reset-strobe case isolate the chain length and the clearing of the update registers.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
  typedef enum logic [1:0] {
    MODE_SYS   = 2'd0,
    MODE_EXT   = 2'd1,
    MODE_CLAMP = 2'd2,
    MODE_HIZ   = 2'd3
  } scan_mode_e;
endpackage

// File: rtl/dbl_rst_sync.sv
module dbl_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/dbl_latch_bank.sv
module dbl_latch_bank #(
  parameter int W = 9
) (
  input  logic [W-1:0] d,
  input  logic         le,
  output logic [W-1:0] q
);
  // Level-sensitive storage: open while le is high
  always_latch begin
    if (le) q = d;
  end
endmodule

// File: rtl/dbl_out_ctl.sv
module dbl_out_ctl
  import dbl_pkg::*;
#(
  parameter int W = 9
) (
  input  scan_mode_e   mode,
  input  logic [W-1:0] sys_q,
  input  logic         sys_en,
  input  logic [W-1:0] tst_q,
  input  logic         tst_en,
  output logic [W-1:0] pin_q,
  output logic         pin_en
);
  always_comb begin
    pin_q  = sys_q;
    pin_en = sys_en;
    case (mode)
      MODE_EXT, MODE_CLAMP: begin
        pin_q  = tst_q;
        pin_en = tst_en;
      end
      MODE_HIZ: pin_en = 1'b0;
      default: ;
    endcase
  end
endmodule

// File: rtl/dbl_bsr.sv
module dbl_bsr #(
  parameter int W = 9
) (
  input  logic                tck,
  input  logic                rst_n,
  input  logic                tdi,
  input  logic                cap_en,
  input  logic                shift_en,
  input  logic                upd_en,
  input  logic                tlr,
  input  logic [4*W+5:0]      cap_vec,
  output logic                tdo,
  output logic [1:0][W-1:0]   upd_q,
  output logic [1:0]          upd_on
);
  localparam int L         = 4*W + 6;
  localparam int IDX_A_EN  = L - 3;
  localparam int IDX_B_EN  = L - 6;
  localparam int A_OUT_TOP = 2*W - 1;
  localparam int B_OUT_TOP = W - 1;

  logic [L-1:0]        sreg, sreg_nxt;
  logic [1:0][W-1:0]   upd_q_r, upd_q_nxt;
  logic [1:0]          upd_on_r, upd_on_nxt;

  // Capture / shift stage (rising edge)
  always_comb begin
    sreg_nxt = sreg;
    if (cap_en)        sreg_nxt = cap_vec;
    else if (shift_en) sreg_nxt = {tdi, sreg[L-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                  sreg <= '0;
    else if (cap_en || shift_en) sreg <= sreg_nxt;
  end

  // Update stage (falling edge), only control cells are kept
  always_comb begin
    upd_q_nxt  = upd_q_r;
    upd_on_nxt = upd_on_r;
    if (tlr) begin
      upd_q_nxt  = '0;
      upd_on_nxt = '0;
    end else if (upd_en) begin
      for (int k = 0; k < W; k++) begin
        upd_q_nxt[0][k] = sreg[A_OUT_TOP - k];
        upd_q_nxt[1][k] = sreg[B_OUT_TOP - k];
      end
      upd_on_nxt = {sreg[IDX_B_EN], sreg[IDX_A_EN]};
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      upd_q_r  <= '0;
      upd_on_r <= '0;
    end else if (tlr || upd_en) begin
      upd_q_r  <= upd_q_nxt;
      upd_on_r <= upd_on_nxt;
    end
  end

  assign tdo    = sreg[0];
  assign upd_q  = upd_q_r;
  assign upd_on = upd_on_r;

  // R4: one shift moves the chain one cell toward tdo
  a_r4_shift_path: assert property (@(posedge tck) disable iff (!rst_n)
    (shift_en && !cap_en) |=> (sreg[L-1] == $past(tdi)) && (sreg[L-2:0] == $past(sreg[L-1:1])));

  // R5: capture loads the whole net image
  a_r5_capture_image: assert property (@(posedge tck) disable iff (!rst_n)
    cap_en |=> (sreg == $past(cap_vec)));

  // R9: test-logic reset clears the update stage
  a_r9_tlr_clears: assert property (@(negedge tck) disable iff (!rst_n)
    tlr |=> (upd_on_r == 2'b00) && (upd_q_r == '0));
endmodule

// File: rtl/dbl_scan_latch.sv
module dbl_scan_latch
  import dbl_pkg::*;
#(
  parameter int W = 9
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         tdi,
  output logic         tdo,
  input  logic         dr_capture,
  input  logic         dr_shift,
  input  logic         dr_update,
  input  logic         tap_reset,
  input  logic [1:0]   scan_mode,
  input  logic [W-1:0] a_in,
  input  logic         a_le,
  input  logic         a_oe_n,
  input  logic [W-1:0] b_in,
  input  logic         b_le,
  input  logic         b_oe_n,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  output logic [W-1:0] b_out,
  output logic         b_drv
);
  localparam int L   = 4*W + 6;
  localparam int NB  = 2;

  logic              rst_n;
  scan_mode_e        mode;
  logic [NB-1:0][W-1:0] din, q, upd_q, pin_q;
  logic [NB-1:0]     le, oe_n, upd_on, pin_en;
  logic [L-1:0]      cap_vec;

  assign mode = scan_mode_e'(scan_mode);
  assign din  = {b_in, a_in};
  assign le   = {b_le, a_le};
  assign oe_n = {b_oe_n, a_oe_n};

  dbl_rst_sync u_rst (
    .clk    (tck),
    .arst_n (trst_n),
    .rst_n  (rst_n)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    dbl_latch_bank #(.W(W)) u_latch (
      .d  (din[g]),
      .le (le[g]),
      .q  (q[g])
    );
    dbl_out_ctl #(.W(W)) u_ctl (
      .mode   (mode),
      .sys_q  (q[g]),
      .sys_en (~oe_n[g]),
      .tst_q  (upd_q[g]),
      .tst_en (upd_on[g]),
      .pin_q  (pin_q[g]),
      .pin_en (pin_en[g])
    );
  end

  // Net image presented to the capture stage
  always_comb begin
    cap_vec        = '0;
    cap_vec[L-1]   = a_oe_n;
    cap_vec[L-2]   = a_le;
    cap_vec[L-3]   = ~a_oe_n;
    cap_vec[L-4]   = b_oe_n;
    cap_vec[L-5]   = b_le;
    cap_vec[L-6]   = ~b_oe_n;
    for (int k = 0; k < W; k++) begin
      cap_vec[4*W-1-k] = a_in[k];
      cap_vec[3*W-1-k] = b_in[k];
      cap_vec[2*W-1-k] = q[0][k];
      cap_vec[W-1-k]   = q[1][k];
    end
  end

  dbl_bsr #(.W(W)) u_bsr (
    .tck      (tck),
    .rst_n    (rst_n),
    .tdi      (tdi),
    .cap_en   (dr_capture),
    .shift_en (dr_shift),
    .upd_en   (dr_update),
    .tlr      (tap_reset),
    .cap_vec  (cap_vec),
    .tdo      (tdo),
    .upd_q    (upd_q),
    .upd_on   (upd_on)
  );

  assign a_out = pin_q[0];
  assign b_out = pin_q[1];
  assign a_drv = pin_en[0];
  assign b_drv = pin_en[1];

  // R1: open latch is transparent at the pins in system mode
  a_r1_transparent: assert property (@(posedge tck) disable iff (!rst_n)
    (mode == MODE_SYS && a_le) |-> (a_out == a_in));
  a_r1_transparent_b: assert property (@(posedge tck) disable iff (!rst_n)
    (mode == MODE_SYS && b_le) |-> (b_out == b_in));

  // R3: pin drive follows the active-low enable pins in system mode
  a_r3_drive_pin: assert property (@(posedge tck) disable iff (!rst_n)
    (mode == MODE_SYS) |-> (a_drv == !a_oe_n) && (b_drv == !b_oe_n));

  // R8: high-Z mode releases both banks
  a_r8_highz: assert property (@(posedge tck) disable iff (!rst_n)
    (mode == MODE_HIZ) |-> (!a_drv && !b_drv));
endmodule

// File: tb/test_dbl_scan_latch.sv
module test_dbl_scan_latch;
  logic       tck = 1'b0;
  logic       trst_n, tdi, tdo, dr_capture, dr_shift, dr_update, tap_reset;
  logic [1:0] scan_mode;
  logic [8:0] a_in, b_in, a_out, b_out;
  logic       a_le, a_oe_n, b_le, b_oe_n, a_drv, b_drv;

  int nchk = 0;
  int nerr = 0;
  logic [8:0] aq_m, bq_m;        // bench latch model
  logic [19:0] upd_m;            // bench update-register model {a_q,a_en,b_q,b_en}

  always #4 tck = ~tck;

  dbl_scan_latch i_dbl_scan_latch (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .tdo(tdo),
    .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
    .tap_reset(tap_reset), .scan_mode(scan_mode),
    .a_in(a_in), .a_le(a_le), .a_oe_n(a_oe_n),
    .b_in(b_in), .b_le(b_le), .b_oe_n(b_oe_n),
    .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wait_neg();
    @(negedge tck);
    #1;
  endtask

  task automatic set_sys(input logic [8:0] ai, input logic ale, input logic aoe,
                         input logic [8:0] bi, input logic ble, input logic boe);
    a_in = ai; a_le = ale; a_oe_n = aoe;
    b_in = bi; b_le = ble; b_oe_n = boe;
    if (ale) aq_m = ai;
    if (ble) bq_m = bi;
    #1;
  endtask

  function automatic logic [41:0] image();
    logic [41:0] v;
    v[41] = a_oe_n; v[40] = a_le; v[39] = ~a_oe_n;
    v[38] = b_oe_n; v[37] = b_le; v[36] = ~b_oe_n;
    for (int k = 0; k < 9; k++) begin
      v[35-k] = a_in[k];
      v[26-k] = b_in[k];
      v[17-k] = aq_m[k];
      v[8-k]  = bq_m[k];
    end
    return v;
  endfunction

  function automatic logic [19:0] ctl_of(input logic [41:0] v);
    logic [19:0] r;
    for (int k = 0; k < 9; k++) begin
      r[11+k] = v[17-k];
      r[1+k]  = v[8-k];
    end
    r[10] = v[39];
    r[0]  = v[36];
    return r;
  endfunction

  function automatic logic [19:0] pins();
    return {a_out, a_drv, b_out, b_drv};
  endfunction

  function automatic logic [19:0] sys_pins();
    return {aq_m, ~a_oe_n, bq_m, ~b_oe_n};
  endfunction

  task automatic shift_only(input logic [41:0] vin, output logic [41:0] vout);
    dr_shift = 1'b1;
    for (int i = 0; i < 42; i++) begin
      tdi = vin[i];
      #1;
      vout[i] = tdo;
      wait_neg();
    end
    dr_shift = 1'b0;
  endtask

  task automatic scan_cycle(input logic [41:0] vin, output logic [41:0] vout, input bit do_upd);
    logic [19:0] snap;
    wait_neg();
    dr_capture = 1'b1;
    wait_neg();
    dr_capture = 1'b0;
    shift_only(vin, vout);
    if (do_upd) begin
      snap = pins();
      dr_update = 1'b1;
      #4;  // past the rising edge, before the falling edge
      chk("R6 pins unchanged before falling edge", 64'(pins()), 64'(snap));
      wait_neg();
      dr_update = 1'b0;
      upd_m = ctl_of(vin);
    end
  endtask

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog expired got timeout exp finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [41:0] vin, vout, v1, v2;
    void'($urandom(32'h1d5c_a7e3));
    trst_n = 1'b0; tdi = 1'b0; dr_capture = 1'b0; dr_shift = 1'b0;
    dr_update = 1'b0; tap_reset = 1'b0; scan_mode = 2'd1;
    aq_m = '0; bq_m = '0; upd_m = '0;
    set_sys(9'h000, 1'b1, 1'b0, 9'h000, 1'b1, 1'b0);
    repeat (3) wait_neg();
    trst_n = 1'b1;
    repeat (4) wait_neg();

    // Reset state: update stage cleared, chain cleared
    chk("R9 reset pins in external test", 64'(pins()), 64'(20'h0));
    chk("R4 reset tdo", 64'(tdo), 64'(1'b0));
    scan_mode = 2'd0;
    #1;

    // R1 directed
    set_sys(9'h1A5, 1'b1, 1'b0, 9'h05A, 1'b1, 1'b0);
    chk("R1 transparent A", 64'(a_out), 64'(9'h1A5));
    chk("R1 transparent B", 64'(b_out), 64'(9'h05A));
    set_sys(9'h0F3, 1'b1, 1'b0, 9'h10C, 1'b1, 1'b0);
    chk("R1 follows change", 64'({a_out, b_out}), 64'({9'h0F3, 9'h10C}));
    // R2 directed
    set_sys(9'h0F3, 1'b0, 1'b0, 9'h10C, 1'b0, 1'b0);
    set_sys(9'h111, 1'b0, 1'b0, 9'h0EE, 1'b0, 1'b0);
    chk("R2 hold after fall", 64'({a_out, b_out}), 64'({9'h0F3, 9'h10C}));
    // R3 directed: disable, load while disabled, re-enable
    set_sys(9'h111, 1'b0, 1'b1, 9'h0EE, 1'b0, 1'b1);
    chk("R3 disabled drive", 64'({a_drv, b_drv}), 64'(2'b00));
    set_sys(9'h155, 1'b1, 1'b1, 9'h0AA, 1'b1, 1'b1);
    set_sys(9'h155, 1'b0, 1'b1, 9'h0AA, 1'b0, 1'b1);
    set_sys(9'h000, 1'b0, 1'b0, 9'h000, 1'b0, 1'b0);
    chk("R3 loaded while disabled", 64'(pins()), 64'({9'h155, 1'b1, 9'h0AA, 1'b1}));

    // Random system traffic against the latch model
    for (int n = 0; n < 300; n++) begin
      wait_neg();
      set_sys(9'($urandom), 1'($urandom), 1'($urandom),
              9'($urandom), 1'($urandom), 1'($urandom));
      chk("R1 R2 R3 random system pins", 64'(pins()), 64'(sys_pins()));
    end

    // R4: pure shift-through, 42 cells
    wait_neg();
    v1 = {10'($urandom), 32'($urandom)};
    v2 = {10'($urandom), 32'($urandom)};
    shift_only(v1, vout);
    shift_only(v2, vout);
    chk("R4 42-shift latency", 64'(vout), 64'(v1));

    // Random capture / update images across all modes
    for (int n = 0; n < 40; n++) begin
      scan_mode = 2'd0;
      set_sys(9'($urandom), 1'($urandom), 1'($urandom),
              9'($urandom), 1'($urandom), 1'($urandom));
      set_sys(a_in, 1'b0, a_oe_n, b_in, 1'b0, b_oe_n);
      set_sys(9'($urandom), 1'b0, 1'($urandom), 9'($urandom), 1'b0, 1'($urandom));
      v1  = image();
      vin = {10'($urandom), 32'($urandom)};
      scan_cycle(vin, vout, 1'b1);
      chk("R5 captured image", 64'(vout), 64'(v1));
      chk("R10 system pins undisturbed", 64'(pins()), 64'(sys_pins()));
      scan_mode = 2'd1; #1;
      chk("R6 external test pins", 64'(pins()), 64'(upd_m));
      scan_mode = 2'd2; #1;
      chk("R7 clamp pins", 64'(pins()), 64'(upd_m));
      scan_mode = 2'd3; #1;
      chk("R8 high-Z drive", 64'({a_drv, b_drv}), 64'(2'b00));
    end

    // Directed: only the A enable cell set
    scan_mode = 2'd0;
    vin = 42'h0;
    vin[39] = 1'b1;
    scan_cycle(vin, vout, 1'b1);
    scan_mode = 2'd1; #1;
    chk("R6 single A enable cell", 64'(pins()), 64'({9'h0, 1'b1, 9'h0, 1'b0}));
    scan_mode = 2'd3; #1;
    chk("R8 high-Z with enable loaded", 64'({a_drv, b_drv}), 64'(2'b00));

    // R9: all-ones update, then test-logic reset
    scan_mode = 2'd0;
    scan_cycle({42{1'b1}}, vout, 1'b1);
    scan_mode = 2'd1; #1;
    chk("R6 all-ones update", 64'(pins()), 64'(20'hFFFFF));
    wait_neg();
    tap_reset = 1'b1;
    wait_neg();
    tap_reset = 1'b0;
    #1;
    chk("R9 tap reset clears update", 64'(pins()), 64'(20'h0));

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule